// File: doc/BRIEF.md
# STS-3 Transmit Scrambler with Overhead Fault Injection

This block sits at the end of an STS-3 transmit byte path, just before the line interface. It takes one byte per clock, together with a start-of-frame strobe on the first framing byte. It tracks the byte position inside the 270-column by 9-row frame and can descramble-proof the stream with the frame-synchronous scrambler that SONET uses. Software can switch the scrambler on or off at runtime.

For testing defect detection at the far end, the same control byte can corrupt or overwrite selected transport overhead. It can flip a bit in the first framing byte, flip a bit in each line parity byte, replace everything after the section overhead with all ones (line AIS), mark the line remote-defect code in the APS byte, or blank the whole output to simulate loss of signal. Overhead is changed before the scrambler, so forced values reach the line scrambled like any other byte. The blanking for loss of signal is the exception and is applied after the scrambler.

The frame position is held by a state machine with five states. ST_UNSYNC holds until the first start-of-frame strobe. ST_FRAMING covers the nine unscrambled bytes at the start of row 0. ST_SECT_OH covers the overhead bytes of rows 1 and 2. ST_LINE_OH covers the overhead bytes of rows 3 to 8. ST_PAYLOAD covers columns 9 to 269 of every row. There are six transitions:
- UNSYNC to FRAMING on the strobe.
- FRAMING to PAYLOAD after column 8 of row 0.
- PAYLOAD to SECT_OH or to LINE_OH at the start of each following row.
- SECT_OH or LINE_OH back to PAYLOAD after column 8.
- PAYLOAD to FRAMING when the frame wraps.
- Any state to FRAMING when a strobe arrives.

Top module: `sts3_tx_scrambler`

## Requirements
- R1: After reset, dout and dout_sof are 0 and ctrl_rdata reads 0x04, which means the scrambler is on and all other controls are off.
- R2: A write with ctrl_wr loads ctrl_wdata[5:0] into the control byte. Bits 7 and 6 always read 0. The new value first applies to the byte presented in the cycle after the write. The bit fields are: 0 = framing error insert, 1 = B2 error insert, 2 = scramble enable, 3 = force LOS, 4 = force line AIS, 5 = force line RDI.
- R3: dout carries the result for the byte presented one clock earlier. dout_sof repeats din_sof with the same one-clock delay.
- R4: A din_sof byte is row 0, column 0. Positions then advance column by column up to 269, and row by row up to 8, then wrap. A new din_sof resynchronises at any time. Before the first din_sof, bytes pass through unchanged apart from R12.
- R5: With bit 2 set, each byte is XORed with 8 bits of the x^7+x^6+1 sequence, taken MSB first. The generator reloads to all ones at row 0, column 9, so the mask of that byte is 0xFE. It advances by 8 steps on every framed byte.
- R6: Row 0, columns 0 to 8 (the framing and trace bytes) are never scrambled.
- R7: With bit 2 clear, framed bytes are not scrambled.
- R8: With bit 0 set, bit 0 of the byte at row 0, column 0 is inverted. No other byte is changed by this bit.
- R9: With bit 1 set, bit 0 of each byte at row 4, columns 0 to 2 (the line parity bytes) is inverted before scrambling.
- R10: With bit 4 set, every byte outside rows 0 to 2 of columns 0 to 8 becomes 0xFF before scrambling. This takes priority over R9 and R11.
- R11: With bit 5 set and bit 4 clear, the low three bits of the byte at row 4, column 6 (the APS byte) become 110 before scrambling. The top five bits are kept.
- R12: With bit 3 set, every dout byte is 0x00 after scrambling. dout_sof is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 8 | Transmit byte |
| din_sof | input | 1 | Marks the first framing byte of a frame |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write value |
| ctrl_rdata | output | 8 | Current control byte |
| dout | output | 8 | Processed byte, one cycle late |
| dout_sof | output | 1 | Start-of-frame strobe aligned with dout |

## Verification
The assertions take for granted that din, din_sof and the control inputs are known values on every clock after reset. They also assume that ctrl_wdata is meaningful whenever ctrl_wr is high. The frame-position checks assume the design's own counters are the only source of row and column, so that a strobe in the middle of a frame is a legal resynchronisation and not an error. The stimulus drives every input on each falling edge from fixed or seeded random values, without ever leaving one floating. It spaces start-of-frame strobes at full frame length, except for one deliberate early strobe, and writes random bytes, including the reserved bits, to the control register.

// File: rtl/sts3_scr_pkg.sv
package sts3_scr_pkg;

    // Frame region of a byte position
    typedef enum logic [2:0] {
        ST_UNSYNC  = 3'd0,
        ST_FRAMING = 3'd1,
        ST_SECT_OH = 3'd2,
        ST_LINE_OH = 3'd3,
        ST_PAYLOAD = 3'd4
    } region_e;

    // Control byte, bits 5..0 (first member is the MSB)
    typedef struct packed {
        logic rdi_force;   // bit 5
        logic ais_force;   // bit 4
        logic los_force;   // bit 3
        logic scr_en;      // bit 2
        logic b2_err;      // bit 1
        logic a1_err;      // bit 0
    } ctrl_t;

    localparam int CTRL_W = 6;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 6'b000100;

endpackage

// File: rtl/sts3_frame_pos.sv
module sts3_frame_pos
    import sts3_scr_pkg::*;
#(
    parameter int N_STS        = 3,
    parameter int COLS_PER_STS = 90,
    parameter int ROWS         = 9,
    parameter int TOH_PER_STS  = 3,
    parameter int SECT_ROWS    = 3,
    localparam int ROW_BYTES   = N_STS * COLS_PER_STS,
    localparam int TOH_W       = N_STS * TOH_PER_STS,
    localparam int COL_W       = $clog2(ROW_BYTES),
    localparam int ROW_W       = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    output logic [ROW_W-1:0] cur_row,
    output logic [COL_W-1:0] cur_col,
    output region_e          cur_region
);

    region_e          state_q, state_d;
    logic [ROW_W-1:0] row_q, row_d;
    logic [COL_W-1:0] col_q, col_d;

    function automatic region_e classify(input logic [ROW_W-1:0] r,
                                         input logic [COL_W-1:0] c);
        region_e res;
        if (c >= COL_W'(TOH_W))
            res = ST_PAYLOAD;
        else if (r == '0)
            res = ST_FRAMING;
        else if (r < ROW_W'(SECT_ROWS))
            res = ST_SECT_OH;
        else
            res = ST_LINE_OH;
        return res;
    endfunction

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_UNSYNC;
            row_q   <= '0;
            col_q   <= '0;
        end else begin
            state_q <= state_d;
            row_q   <= row_d;
            col_q   <= col_d;
        end
    end

    // Outputs: position of the byte on the input this cycle
    always_comb begin
        cur_row    = '0;
        cur_col    = '0;
        cur_region = ST_UNSYNC;
        if (sof) begin
            cur_region = ST_FRAMING;
        end else begin
            unique case (state_q)
                ST_UNSYNC: cur_region = ST_UNSYNC;
                ST_FRAMING, ST_SECT_OH, ST_LINE_OH, ST_PAYLOAD: begin
                    cur_row    = row_q;
                    cur_col    = col_q;
                    cur_region = state_q;
                end
                default: cur_region = ST_UNSYNC;
            endcase
        end
    end

    // Transitions: region of the next expected byte
    always_comb begin
        col_d   = col_q;
        row_d   = row_q;
        state_d = state_q;
        if (cur_region != ST_UNSYNC) begin
            if (cur_col == COL_W'(ROW_BYTES - 1)) begin
                col_d = '0;
                row_d = (cur_row == ROW_W'(ROWS - 1)) ? '0 : cur_row + 1'b1;
            end else begin
                col_d = cur_col + 1'b1;
                row_d = cur_row;
            end
            state_d = classify(row_d, col_d);
        end
    end

endmodule

// File: rtl/sts3_scr_lfsr.sv
module sts3_scr_lfsr #(
    parameter int LFSR_W = 7,
    parameter int TAP    = 6,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload,
    input  logic              advance,
    output logic [BYTE_W-1:0] mask
);

    logic [LFSR_W-1:0] st_q, st_d, seed;

    always_comb begin
        seed = reload ? {LFSR_W{1'b1}} : st_q;
        st_d = seed;
        mask = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            mask[BYTE_W-1-i] = st_d[LFSR_W-1];
            st_d = {st_d[LFSR_W-2:0], st_d[LFSR_W-1] ^ st_d[TAP-1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= {LFSR_W{1'b1}};
        else if (advance)
            st_q <= st_d;
    end

endmodule

// File: rtl/sts3_oh_inject.sv
module sts3_oh_inject
    import sts3_scr_pkg::*;
#(
    parameter int N_STS  = 3,
    parameter int B2_ROW = 4,
    parameter int COL_W  = 9,
    parameter int ROW_W  = 4
) (
    input  logic [7:0]       din,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  region_e          region,
    input  ctrl_t            ctrl,
    output logic [7:0]       sub_byte,
    output logic             scr_ok
);

    logic is_a1, is_b2, is_k2, in_line;

    always_comb begin
        is_a1   = (region == ST_FRAMING) && (col == '0);
        is_b2   = (region == ST_LINE_OH) && (row == ROW_W'(B2_ROW)) &&
                  (col < COL_W'(N_STS));
        is_k2   = (region == ST_LINE_OH) && (row == ROW_W'(B2_ROW)) &&
                  (col == COL_W'(2 * N_STS));
        in_line = (region == ST_LINE_OH) || (region == ST_PAYLOAD);
        scr_ok  = (region == ST_SECT_OH) || in_line;

        sub_byte = din;
        if (is_a1 && ctrl.a1_err)
            sub_byte[0] = ~sub_byte[0];
        if (is_b2 && ctrl.b2_err)
            sub_byte[0] = ~sub_byte[0];
        if (in_line && ctrl.ais_force)
            sub_byte = 8'hFF;
        else if (is_k2 && ctrl.rdi_force)
            sub_byte[2:0] = 3'b110;
    end

endmodule

// File: rtl/sts3_tx_scrambler.sv
module sts3_tx_scrambler
    import sts3_scr_pkg::*;
#(
    parameter int N_STS        = 3,
    parameter int COLS_PER_STS = 90,
    parameter int ROWS         = 9,
    parameter int TOH_PER_STS  = 3,
    parameter int B2_ROW       = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] din,
    input  logic       din_sof,
    input  logic       ctrl_wr,
    input  logic [7:0] ctrl_wdata,
    output logic [7:0] ctrl_rdata,
    output logic [7:0] dout,
    output logic       dout_sof
);

    localparam int ROW_BYTES = N_STS * COLS_PER_STS;
    localparam int TOH_W     = N_STS * TOH_PER_STS;
    localparam int COL_W     = $clog2(ROW_BYTES);
    localparam int ROW_W     = $clog2(ROWS);

    ctrl_t            ctrl_q;
    logic [ROW_W-1:0] pos_row;
    logic [COL_W-1:0] pos_col;
    region_e          pos_region;
    logic [7:0]       scr_mask, sub_byte, scr_byte, fin_byte;
    logic             scr_ok, lfsr_reload, lfsr_adv;
    logic [7:0]       dout_q;
    logic             dout_sof_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= ctrl_t'(CTRL_RESET);
        else if (ctrl_wr)
            ctrl_q <= ctrl_t'(ctrl_wdata[CTRL_W-1:0]);
    end
    assign ctrl_rdata = {{(8 - CTRL_W){1'b0}}, ctrl_q};

    sts3_frame_pos #(
        .N_STS(N_STS), .COLS_PER_STS(COLS_PER_STS), .ROWS(ROWS),
        .TOH_PER_STS(TOH_PER_STS), .SECT_ROWS(3)
    ) pos_i (
        .clk(clk), .rst_n(rst_n), .sof(din_sof),
        .cur_row(pos_row), .cur_col(pos_col), .cur_region(pos_region)
    );

    assign lfsr_reload = (pos_region == ST_PAYLOAD) && (pos_row == '0) &&
                         (pos_col == COL_W'(TOH_W));
    assign lfsr_adv    = (pos_region != ST_UNSYNC);

    sts3_scr_lfsr #(.LFSR_W(7), .TAP(6), .BYTE_W(8)) lfsr_i (
        .clk(clk), .rst_n(rst_n), .reload(lfsr_reload),
        .advance(lfsr_adv), .mask(scr_mask)
    );

    sts3_oh_inject #(
        .N_STS(N_STS), .B2_ROW(B2_ROW), .COL_W(COL_W), .ROW_W(ROW_W)
    ) inj_i (
        .din(din), .row(pos_row), .col(pos_col), .region(pos_region),
        .ctrl(ctrl_q), .sub_byte(sub_byte), .scr_ok(scr_ok)
    );

    assign scr_byte = (ctrl_q.scr_en && scr_ok) ? (sub_byte ^ scr_mask) : sub_byte;
    assign fin_byte = ctrl_q.los_force ? 8'h00 : scr_byte;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q     <= '0;
            dout_sof_q <= 1'b0;
        end else begin
            dout_q     <= fin_byte;
            dout_sof_q <= din_sof;
        end
    end
    assign dout     = dout_q;
    assign dout_sof = dout_sof_q;

endmodule

// File: rtl/sts3_tx_scrambler_chk.sv
module sts3_tx_scrambler_chk #(
    parameter int ROW_BYTES = 270,
    parameter int ROWS      = 9,
    parameter int COL_W     = 9,
    parameter int ROW_W     = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       din,
    input logic             din_sof,
    input logic             ctrl_wr,
    input logic [7:0]       ctrl_wdata,
    input logic [7:0]       ctrl_rdata,
    input logic [7:0]       dout,
    input logic             dout_sof,
    input logic [COL_W-1:0] pos_col,
    input logic [ROW_W-1:0] pos_row
);

    AST_SOF_DELAY_HI: assert property (@(posedge clk) disable iff (!rst_n)
        din_sof |=> dout_sof); // R3
    AST_SOF_DELAY_LO: assert property (@(posedge clk) disable iff (!rst_n)
        !din_sof |=> !dout_sof); // R3
    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> ctrl_rdata[5:0] == $past(ctrl_wdata[5:0])); // R2
    AST_LOS_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[3] |=> dout == 8'h00); // R12
    AST_FRAMING_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (din_sof && !ctrl_rdata[0] && !ctrl_rdata[3]) |=> dout == $past(din)); // R6
    AST_A1_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (din_sof && ctrl_rdata[0] && !ctrl_rdata[3]) |=> dout == ($past(din) ^ 8'h01)); // R8
    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_col < COL_W'(ROW_BYTES)) && (pos_row < ROW_W'(ROWS))); // R4

endmodule

bind sts3_tx_scrambler sts3_tx_scrambler_chk #(
    .ROW_BYTES(ROW_BYTES), .ROWS(ROWS), .COL_W(COL_W), .ROW_W(ROW_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .din(din), .din_sof(din_sof),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .dout(dout), .dout_sof(dout_sof), .pos_col(pos_col), .pos_row(pos_row)
);

// File: tb/sts3_tx_scrambler_tb.sv
`timescale 1ns/1ps
module sts3_tx_scrambler_tb_top;

    localparam int ROW_BYTES = 270;
    localparam int ROWS      = 9;
    localparam int TOH_W     = 9;
    localparam int FRAME     = ROW_BYTES * ROWS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = '0;
    logic       din_sof = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic [7:0] ctrl_rdata, dout;
    logic       dout_sof;

    int n_checks = 0;
    int n_fail   = 0;

    // model state
    bit       m_sync = 0;
    int       m_row = 0, m_col = 0;
    bit [5:0] m_ctrl = 6'b000100;
    bit [6:0] m_lfsr = 7'h7F;

    always #2 clk = ~clk;

    sts3_tx_scrambler dut_i (
        .clk(clk), .rst_n(rst_n), .din(din), .din_sof(din_sof),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .dout(dout), .dout_sof(dout_sof)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic bit [7:0] gen_mask();
        bit [7:0] mk;
        for (int i = 0; i < 8; i++) begin
            mk = {mk[6:0], m_lfsr[6]};
            m_lfsr = {m_lfsr[5:0], m_lfsr[6] ^ m_lfsr[5]};
        end
        return mk;
    endfunction

    // Drive one byte at a falling edge, check it at the next falling edge
    task automatic do_byte(input bit [7:0] d, input bit s, input bit wr, input bit [7:0] wd);
        bit [7:0] e, mk;
        string    tag;
        bit       framing, sect, line_oh, payload, scr;
        if (s) begin m_sync = 1; m_row = 0; m_col = 0; end
        e = d; tag = "R4";
        if (m_sync) begin
            if (m_row == 0 && m_col == TOH_W) m_lfsr = 7'h7F;
            mk      = gen_mask();
            framing = (m_row == 0) && (m_col < TOH_W);
            sect    = (m_row > 0) && (m_row < 3) && (m_col < TOH_W);
            line_oh = (m_row >= 3) && (m_col < TOH_W);
            payload = (m_col >= TOH_W);
            tag     = framing ? "R6" : (m_ctrl[2] ? "R5" : "R7");
            if (framing && m_col == 0 && m_ctrl[0]) begin e[0] = ~e[0]; tag = "R8"; end
            if (m_row == 4 && m_col < 3 && m_ctrl[1]) begin e[0] = ~e[0]; tag = "R9"; end
            if ((line_oh || payload) && m_ctrl[4]) begin e = 8'hFF; tag = "R10"; end
            else if (m_row == 4 && m_col == 6 && m_ctrl[5]) begin e[2:0] = 3'b110; tag = "R11"; end
            scr = m_ctrl[2] && (sect || line_oh || payload);
            if (scr) e = e ^ mk;
            if (m_col == ROW_BYTES - 1) begin
                m_col = 0;
                m_row = (m_row == ROWS - 1) ? 0 : m_row + 1;
            end else m_col++;
        end
        if (m_ctrl[3]) begin e = 8'h00; tag = "R12"; end
        din = d; din_sof = s; ctrl_wr = wr; ctrl_wdata = wd;
        if (wr) m_ctrl = wd[5:0];
        @(negedge clk);
        check(dout == e, tag, dout, e);
        check(dout_sof == s, "R3", dout_sof, s);
        if (wr) check(ctrl_rdata == {2'b00, wd[5:0]}, "R2", ctrl_rdata, {2'b00, wd[5:0]});
    endtask

    task automatic run_frame(input int len, input bit zero_data, input bit wr0,
                             input bit [7:0] wd0, input int mid_at);
        for (int i = 0; i < len; i++) begin
            bit [7:0] d = zero_data ? 8'h00 : 8'($urandom);
            bit       w = (i == 0) ? wr0 : (i == mid_at);
            bit [7:0] wd = (i == 0) ? wd0 : 8'($urandom & 32'hF7);
            do_byte(d, i == 0, w, wd);
            if (zero_data && i == TOH_W && m_ctrl == 6'b000100)
                check(dout == 8'hFE, "R5", dout, 8'hFE);
        end
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(dout == 8'h00, "R1", dout, 0);
        check(dout_sof == 1'b0, "R1", dout_sof, 0);
        check(ctrl_rdata == 8'h04, "R1", ctrl_rdata, 8'h04);
        // unsynchronised passthrough, then forced LOS while unsynchronised
        for (int i = 0; i < 40; i++) do_byte(8'($urandom), 0, i == 39, 8'hC8);
        for (int i = 0; i < 10; i++) do_byte(8'($urandom), 0, i == 9, 8'h04);
        // directed frames
        run_frame(FRAME, 1, 0, 8'h00, -1);        // R5 zero data, mask check
        run_frame(FRAME, 0, 1, 8'h00, -1);        // R7 scrambler off
        run_frame(FRAME, 0, 1, 8'h07, -1);        // R8 R9
        run_frame(FRAME, 0, 1, 8'h14, -1);        // R10
        run_frame(FRAME, 0, 1, 8'h24, -1);        // R11
        run_frame(FRAME, 0, 1, 8'h37, -1);        // R10 over R11 and R9
        run_frame(1000, 0, 1, 8'h27, -1);         // R4 early resync follows
        run_frame(FRAME, 0, 1, 8'h0C, -1);        // R12 blanking
        // random control
        for (int f = 0; f < 8; f++)
            run_frame(FRAME, 0, 1, 8'($urandom & 32'hF7), int'($urandom_range(1, FRAME - 1)));
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule